// File: doc/BRIEF.md
# RAM-Backed Ternary Match Table

This block provides a small ternary match table built from a plain RAM array rather than from compare cells. The RAM is `SD` words deep and `SW` bits wide. Each RAM bit column belongs to one rule, and the search key supplies the RAM address. The array is split into `N` equal sub-blocks. Each sub-block takes its own slice of the key as an offset, and the words read from all sub-blocks are ANDed together. The result is a match vector with one bit per rule. The emulated key is `N*log2(SD/N)` bits wide: with `SD=16` and one rule column, that is 4 key bits for `N=1`, 6 for `N=2` and 8 for `N=4`.

Rules are loaded through an update port. An update names a column, a value and a care mask, or it asks for the column to be deleted. The block then walks every RAM address, one per clock. At each address it writes the column bit as 1 or 0, depending on whether that address is consistent with the rule. While the walk runs, both the update port and the search port hold their ready signals low. A search returns the full match vector, a hit flag and the index of the lowest-numbered matching column.

Top module: `tcam_ram_emu`

## Requirements
- R1: After reset every column is empty: searches report no hit and a zero match vector, `res_valid` is low, and `search_ready` and `upd_ready` are high.
- R2: The key is split into N slices of `CW = log2(SD/N)` bits. Slice i is `search_key[i*CW +: CW]` and addresses sub-block i, which occupies RAM words `i*SD/N` to `(i+1)*SD/N-1`. Swapping two slices of a key therefore changes the result.
- R3: A written rule matches a key exactly when the key equals `upd_value` at every bit where `upd_care` is 1. Bits where `upd_care` is 0 are don't-care.
- R4: Bit c of `res_match` is 1 exactly when column c holds a rule that matches the key. Several bits may be set at once.
- R5: A search accepted on a clock edge (`search_valid` and `search_ready` both high) gives `res_valid` high for exactly one cycle after that edge. Back-to-back searches give back-to-back results, and no result appears without an accepted search.
- R6: When at least one column matches, `res_hit` is 1 and `res_index` is the lowest matching column number.
- R7: When no column matches, `res_hit` is 0 and `res_index` is 0.
- R8: An update with `upd_delete=1` clears the column, so that column never matches afterwards.
- R9: An accepted update holds `search_ready` and `upd_ready` low for exactly SD cycles. A `search_valid` raised in that window produces no result.
- R10: Writing a column that already holds a rule replaces the old rule entirely.
- R11: An `upd_valid` raised while an update is running is ignored and does not change the table.
- R12: When a search and an update are accepted on the same edge, the search reports the table as it was before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_valid | input | 1 | Update request |
| upd_ready | output | 1 | Update port free (no walk running) |
| upd_delete | input | 1 | 1 = delete the column, 0 = write a rule |
| upd_col | input | IW | Target column (rule number) |
| upd_value | input | KW | Rule value |
| upd_care | input | KW | Care mask, 1 = bit is compared |
| search_valid | input | 1 | Search request |
| search_ready | output | 1 | Search accepted when high |
| search_key | input | KW | Search key |
| res_valid | output | 1 | Result strobe |
| res_match | output | SW | Per-column match vector |
| res_hit | output | 1 | At least one column matched |
| res_index | output | IW | Lowest matching column |

## Verification
The bench targets the slice routing by searching a key and the same key with its slices swapped. A design that addresses the wrong sub-block would report a hit on the swapped key. It checks several rules matching one key at once, so an encoder that favours the highest column, or one that keeps a stale index, gives the wrong `res_index`. It times the busy window and raises requests inside it. An off-by-one walk would leave the last address unwritten, and a design that accepts requests while busy would change the table or emit an extra result. A search issued on the same edge as an update confirms that the search reads the old table, and rewrite and delete steps confirm that old rule bits do not linger.

// File: rtl/tcam_ram_emu.sv
module tcam_ram_emu #(
  parameter int SD = 16,
  parameter int SW = 8,
  parameter int N  = 2,
  localparam int AW  = $clog2(SD),
  localparam int SBD = SD / N,
  localparam int CW  = $clog2(SBD),
  localparam int KW  = N * CW,
  localparam int IW  = (SW > 1) ? $clog2(SW) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd_valid,
  output logic          upd_ready,
  input  logic          upd_delete,
  input  logic [IW-1:0] upd_col,
  input  logic [KW-1:0] upd_value,
  input  logic [KW-1:0] upd_care,
  input  logic          search_valid,
  output logic          search_ready,
  input  logic [KW-1:0] search_key,
  output logic          res_valid,
  output logic [SW-1:0] res_match,
  output logic          res_hit,
  output logic [IW-1:0] res_index
);

  logic [SW-1:0] mem [SD];
  logic          busy;
  logic [AW-1:0] wptr;
  logic          del_q;
  logic [IW-1:0] col_q;
  logic [KW-1:0] val_q, care_q;

  assign upd_ready    = !busy;
  assign search_ready = !busy;

  wire upd_go  = upd_valid && !busy;
  wire srch_go = search_valid && !busy;

  // bit to store at the current walk address
  logic [CW-1:0] off, vchunk, cchunk;
  logic          wbit;
  always_comb begin
    off    = wptr[CW-1:0];
    vchunk = '0;
    cchunk = '0;
    for (int i = 0; i < N; i++)
      if (int'(wptr) / SBD == i) begin
        vchunk = val_q[i*CW +: CW];
        cchunk = care_q[i*CW +: CW];
      end
    wbit = !del_q && (((off ^ vchunk) & cchunk) == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      wptr   <= '0;
      del_q  <= 1'b0;
      col_q  <= '0;
      val_q  <= '0;
      care_q <= '0;
    end else if (upd_go) begin
      busy   <= 1'b1;
      wptr   <= '0;
      del_q  <= upd_delete;
      col_q  <= upd_col;
      val_q  <= upd_value;
      care_q <= upd_care;
    end else if (busy) begin
      wptr <= wptr + 1'b1;
      if (wptr == AW'(SD - 1)) busy <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int a = 0; a < SD; a++) mem[a] <= '0;
    end else if (busy) begin
      mem[wptr][col_q] <= wbit;
    end
  end

  // one read per sub-block, all within the search cycle
  logic [SW-1:0] rd [N];
  for (genvar gi = 0; gi < N; gi++) begin : g_sub
    assign rd[gi] = mem[AW'(gi * SBD) + AW'(search_key[gi*CW +: CW])];
  end

  logic [SW-1:0] hitv;
  logic [IW-1:0] idx;
  always_comb begin
    hitv = '1;
    for (int i = 0; i < N; i++) hitv &= rd[i];
    idx = '0;
    for (int c = SW - 1; c >= 0; c--)
      if (hitv[c]) idx = IW'(c);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_match <= '0;
      res_hit   <= 1'b0;
      res_index <= '0;
    end else begin
      res_valid <= srch_go;
      if (srch_go) begin
        res_match <= hitv;
        res_hit   <= |hitv;
        res_index <= idx;
      end
    end
  end

  logic [AW:0] run_q;
  always_ff @(posedge clk) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= busy ? run_q + 1'b1 : '0;
  end

  p_walk_bounded_r9: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= (AW+1)'(SD));
  p_walk_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> run_q == (AW+1)'(SD));
  p_upd_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_ready) |=> (!search_ready && !upd_ready));
  p_result_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(search_valid && search_ready));
  p_hit_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_hit == (|res_match)));
  p_miss_index_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_hit) |-> res_index == '0);
  p_lowest_index_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_hit) |->
      (res_match[res_index] && ((res_match & ((SW'(1) << res_index) - SW'(1))) == '0)));

endmodule

// File: tb/test_tcam_ram_emu.sv
module test_tcam_ram_emu;
  localparam int SD = 16, SW = 8, N = 2;
  localparam int CW = $clog2(SD / N);
  localparam int KW = N * CW;
  localparam int IW = $clog2(SW);

  logic clk = 1'b0, rst_n = 1'b0;
  logic upd_valid = 1'b0, upd_delete = 1'b0;
  logic [IW-1:0] upd_col = '0;
  logic [KW-1:0] upd_value = '0, upd_care = '0;
  logic search_valid = 1'b0;
  logic [KW-1:0] search_key = '0;
  logic upd_ready, search_ready, res_valid, res_hit;
  logic [SW-1:0] res_match;
  logic [IW-1:0] res_index;

  always #4 clk = ~clk;

  tcam_ram_emu #(.SD(SD), .SW(SW), .N(N)) i_tcam_ram_emu (
    .clk(clk), .rst_n(rst_n),
    .upd_valid(upd_valid), .upd_ready(upd_ready), .upd_delete(upd_delete),
    .upd_col(upd_col), .upd_value(upd_value), .upd_care(upd_care),
    .search_valid(search_valid), .search_ready(search_ready), .search_key(search_key),
    .res_valid(res_valid), .res_match(res_match), .res_hit(res_hit), .res_index(res_index));

  typedef struct { logic [SW-1:0] m; logic h; logic [IW-1:0] ix; string tag; } exp_t;
  exp_t q[$];
  logic [KW-1:0] mval [SW];
  logic [KW-1:0] mcare [SW];
  bit mon [SW];
  int checks = 0, fails = 0, cyc = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic exp_t predict(input logic [KW-1:0] key, input string tag);
    exp_t e;
    e.m = '0;
    for (int c = 0; c < SW; c++)
      if (mon[c] && (((key ^ mval[c]) & mcare[c]) == '0)) e.m[c] = 1'b1;
    e.h = |e.m;
    e.ix = '0;
    for (int c = SW - 1; c >= 0; c--) if (e.m[c]) e.ix = IW'(c);
    e.tag = tag;
    return e;
  endfunction

  task automatic do_search(input logic [KW-1:0] key, input string tag);
    while (!search_ready) begin @(posedge clk); #1; end
    search_valid = 1'b1;
    search_key = key;
    q.push_back(predict(key, tag));
    @(posedge clk); #1;
    search_valid = 1'b0;
  endtask

  task automatic do_update(input bit del, input int col,
                           input logic [KW-1:0] val, input logic [KW-1:0] care);
    while (!upd_ready) begin @(posedge clk); #1; end
    upd_valid = 1'b1; upd_delete = del; upd_col = IW'(col);
    upd_value = val; upd_care = care;
    @(posedge clk); #1;
    upd_valid = 1'b0;
    mon[col] = !del; mval[col] = val; mcare[col] = care;
  endtask

  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (q.size() == 0) chk(1'b0, "R9", "unexpected result", 32'(res_match), 0);
      else begin
        exp_t e;
        e = q.pop_front();
        chk(res_match == e.m, e.tag, "match", 32'(res_match), 32'(e.m));
        chk(res_hit == e.h, e.tag, "hit", 32'(res_hit), 32'(e.h));
        chk(res_index == e.ix, e.tag, "index", 32'(res_index), 32'(e.ix));
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 50000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < SW; c++) begin mon[c] = 0; mval[c] = '0; mcare[c] = '0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!res_valid, "R1", "res_valid", 32'(res_valid), 0);
    chk(search_ready && upd_ready, "R1", "ready", 32'({search_ready, upd_ready}), 3);
    @(posedge clk); #1;
    do_search(6'h00, "R1");
    do_search(6'h3F, "R1");

    do_update(0, 3, 6'h2B, 6'h3F);
    begin
      int n = 0;
      while (!search_ready) begin n++; @(posedge clk); #1; end
      chk(n == SD, "R9", "busy cycles", n, SD);
    end
    do_search(6'h2B, "R3");
    do_search(6'h2A, "R3");
    do_search(6'h1B, "R2");

    do_update(0, 5, 6'h02, 6'h07);
    do_search(6'h02, "R3");
    do_search(6'h3A, "R3");
    do_search(6'h12, "R3");
    do_search(6'h03, "R3");

    do_update(0, 1, 6'h28, 6'h38);
    do_search(6'h2B, "R4");
    do_search(6'h2B, "R6");
    do_search(6'h2F, "R4");

    do_update(0, 7, 6'h0E, 6'h3F);
    do_search(6'h0E, "R2");
    do_search(6'h31, "R2");

    // requests inside the busy window
    do_update(0, 6, 6'h15, 6'h3F);
    @(posedge clk); #1;
    search_valid = 1'b1; search_key = 6'h15;
    upd_valid = 1'b1; upd_delete = 1'b0; upd_col = 0; upd_value = '0; upd_care = '0;
    @(posedge clk); #1;
    search_valid = 1'b0; upd_valid = 1'b0;
    do_search(6'h00, "R11");
    do_search(6'h15, "R9");

    do_update(0, 3, 6'h00, 6'h3F);
    do_search(6'h2B, "R10");
    do_search(6'h00, "R10");

    do_update(1, 1, 6'h00, 6'h00);
    do_search(6'h2B, "R8");
    do_search(6'h28, "R8");

    // same-edge search and update
    search_valid = 1'b1; search_key = 6'h3C;
    upd_valid = 1'b1; upd_delete = 1'b0; upd_col = 0; upd_value = '0; upd_care = '0;
    q.push_back(predict(6'h3C, "R12"));
    @(posedge clk); #1;
    search_valid = 1'b0; upd_valid = 1'b0;
    mon[0] = 1; mval[0] = '0; mcare[0] = '0;
    do_search(6'h3C, "R12");
    do_search(6'h0E, "R6");

    // single search: strobe lasts exactly one cycle
    @(negedge clk);
    chk(res_valid, "R5", "strobe on", 32'(res_valid), 1);
    @(negedge clk);
    chk(!res_valid, "R5", "strobe off", 32'(res_valid), 0);
    @(posedge clk); #1;

    for (int c = 0; c < SW; c++) do_update(1, c, '0, '0);
    do_search(6'h00, "R7");
    do_search(6'h0E, "R7");
    do_search(6'h15, "R7");

    repeat (4) @(posedge clk);
    chk(q.size() == 0, "R5", "results outstanding", q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule